// File: doc/BRIEF.md
# Eight-Bit ALU with Registered Condition Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. It combines an accumulator value with an operand under a 4-bit operation code and returns the value to be written back on the same cycle, without a clock. A four-flag status register (negative, zero, carry, overflow) sits beside the datapath and takes new values on the clock edge. The operations are add with carry, subtract with borrow, AND, OR, XOR, compare, shift left and shift right. A move code passes the operand through and leaves every flag alone.

When the decimal input is high, add and subtract treat both bytes as two packed BCD digits and correct the result to BCD. Two variants differ in where the negative flag comes from during such an operation. By default it copies the top bit of the raw binary sum, taken before decimal correction. With `LATE_DEC_N` set, it copies the top bit of the corrected result. The status register changes only when the update enable is high, and only for the flags that the current operation defines. A synchronous reset clears the status register.

Top module: `alu8_status`

## Requirements
- R1: Add (code 0, decimal low): result = (acc + opnd + carry_in) mod 256. C takes the carry out of bit 7. V is set when acc and opnd have the same bit 7 and the result's bit 7 differs from it. N takes result bit 7.
- R2: Subtract (code 1, decimal low): result = (acc + ~opnd + carry_in) mod 256, so C=1 means no borrow. V uses the same sign rule with ~opnd as the second operand. N takes result bit 7.
- R3: AND (code 2), OR (code 3) and XOR (code 4) return the bitwise result. N takes result bit 7. C and V keep their previous values.
- R4: Compare (code 5) returns acc unchanged. It forms acc + ~opnd + 1 and takes N from bit 7 of that difference, Z from whether the difference is zero, and C from its carry out. V keeps its previous value.
- R5: Shift left (code 6): result = acc << 1 with a zero in bit 0. C takes old bit 7 and N takes old bit 6. V is kept.
- R6: Shift right (code 7): result = acc >> 1 with a zero in bit 7. C takes old bit 0 and N is always cleared. V is kept.
- R7: For every code that updates flags, Z is 1 exactly when the value the flags describe (the result, or the difference for compare) has all eight bits zero.
- R8: Add or subtract with decimal high and valid BCD inputs gives a BCD result. Add gives (acc + opnd + carry_in) mod 100 with C set on a decimal carry. Subtract gives (acc - opnd - (1 - carry_in)) mod 100 with C=1 when no borrow occurred. V follows the binary sum rules of R1/R2.
- R9: In decimal add/subtract, N is bit 7 of the uncorrected binary sum when LATE_DEC_N=0, and bit 7 of the corrected BCD result when LATE_DEC_N=1.
- R10: Code 8 and the unused codes 9 to 15 return opnd as the result and leave all four flags unchanged, even with the update enable high.
- R11: With flag_we low, no flag changes on the clock edge, whatever the operation.
- R12: A synchronous reset clears N, Z, C and V to 0 on the clock edge.

Parameters: `DATA_W` (must be 8 or a larger multiple of 4) and `LATE_DEC_N`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous reset, active high, clears flags |
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 AND, 3 OR, 4 XOR, 5 compare, 6 shift left, 7 shift right, 8-15 move) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry into add/subtract |
| dec_mode | input | 1 | Decimal (BCD) mode for add/subtract |
| flag_we | input | 1 | Status register update enable |
| result | output | 8 | Combinational result to write back |
| n_flag | output | 1 | Registered negative flag |
| z_flag | output | 1 | Registered zero flag |
| c_flag | output | 1 | Registered carry flag |
| v_flag | output | 1 | Registered overflow flag |

## Verification
The bench targets the decimal add 0x79 + 0x01. Its raw sum has bit 7 clear and its corrected sum 0x80 has bit 7 set, so a design that picks the wrong N source for the selected variant reports the wrong sign. Decimal 0x99 + 0x01 leaves Z and N both set under the default variant. That catches a design that derives N from the stored byte, or that forces N low whenever Z is set. The bench also runs 0x7F + 0x01 for signed overflow and shift-left of 0x40 to test N from old bit 6. It checks that compare leaves the accumulator untouched, because a design that writes back the difference would corrupt it. Move codes and a low enable follow updates that set a known flag pattern, so a design that writes flags when it should not changes a visible flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_CMP  = 4'd5,
      OP_SHL  = 4'd6,
      OP_SHR  = 4'd7,
      OP_MOVE = 4'd8
   } alu_op_e;

   localparam int FLG_V     = 0;
   localparam int FLG_C     = 1;
   localparam int FLG_Z     = 2;
   localparam int FLG_N     = 3;
   localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   input  logic              dec,
   output logic [DATA_W-1:0] sum,
   output logic              raw_msb,
   output logic              cout,
   output logic              ovf
);
   localparam int DIGITS = DATA_W / 4;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;
   logic              c_into_msb;
   logic [DIGITS:0]   dchain;
   logic [DATA_W-1:0] dsum;

   assign b_eff      = sub ? ~b : b;
   assign wide       = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
   assign c_into_msb = a[DATA_W-1] ^ b_eff[DATA_W-1] ^ wide[DATA_W-1];
   assign ovf        = c_into_msb ^ wide[DATA_W];
   assign raw_msb    = wide[DATA_W-1];
   assign dchain[0]  = cin;

   // one BCD digit stage per nibble; chain carries carry (add) or no-borrow (sub)
   for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
      logic [3:0] ad, bd, dig;
      logic [4:0] s_add, s_sub;
      logic       nxt;
      assign ad = a[4*gi +: 4];
      assign bd = b[4*gi +: 4];
      always_comb begin
         s_add = {1'b0, ad} + {1'b0, bd} + {4'b0000, dchain[gi]};
         s_sub = {1'b0, ad} - {1'b0, bd} - {4'b0000, ~dchain[gi]};
         if (sub) begin
            nxt = ~s_sub[4];
            dig = s_sub[4] ? (s_sub[3:0] + 4'd10) : s_sub[3:0];
         end else begin
            nxt = (s_add > 5'd9);
            dig = nxt ? (s_add[3:0] + 4'd6) : s_add[3:0];
         end
      end
      assign dsum[4*gi +: 4] = dig;
      assign dchain[gi+1]    = nxt;
   end

   assign sum  = dec ? dsum : wide[DATA_W-1:0];
   assign cout = dec ? dchain[DIGITS] : wide[DATA_W];

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
         OP_SHR:  y = {1'b0, a[DATA_W-1:1]};
         default: y = b;
      endcase
   end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [NF-1:0] mask,
   input  logic [NF-1:0] nxt,
   output logic [NF-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we) q <= (q & ~mask) | (nxt & mask);
   end

   assert_reset_clear_R12: assert property (@(posedge clk) rst |=> q == '0);
   assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));
   assert_masked_keep_R10: assert property (@(posedge clk) disable iff (rst)
      (we && mask == '0) |=> $stable(q));
endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit LATE_DEC_N = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic              carry_in,
   input  logic              dec_mode,
   input  logic              flag_we,
   output logic [DATA_W-1:0] result,
   output logic              n_flag,
   output logic              z_flag,
   output logic              c_flag,
   output logic              v_flag
);
   localparam int MSB = DATA_W - 1;

   if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_width
      $error("alu8_status: DATA_W must be a multiple of 4 and at least 8");
   end

   logic              is_arith, is_cmp, use_sub, use_dec, use_cin;
   logic [DATA_W-1:0] as_sum, bit_y;
   logic              as_raw_msb, as_cout, as_ovf, n_arith;
   logic [NUM_FLAGS-1:0] fl_nxt, fl_mask, fl_q;

   assign is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);
   assign is_cmp   = (op_sel == OP_CMP);
   assign use_sub  = (op_sel == OP_SUB) || is_cmp;
   assign use_dec  = dec_mode && is_arith;
   assign use_cin  = is_cmp ? 1'b1 : carry_in;

   alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a(acc_in), .b(opnd_in), .cin(use_cin), .sub(use_sub), .dec(use_dec),
      .sum(as_sum), .raw_msb(as_raw_msb), .cout(as_cout), .ovf(as_ovf)
   );

   alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op(op_sel), .a(acc_in), .b(opnd_in), .y(bit_y)
   );

   // sign source for add/subtract picked by variant
   if (LATE_DEC_N) begin : g_n_late
      assign n_arith = as_sum[MSB];
      assert_bin_agree_R9: assert property (@(posedge clk) disable iff (rst)
         (is_arith && !dec_mode) |-> (as_raw_msb == as_sum[MSB]));
   end else begin : g_n_early
      assign n_arith = as_raw_msb;
      assert_n_raw_R9: assert property (@(posedge clk) disable iff (rst)
         (flag_we && is_arith && dec_mode) |=> (n_flag == $past(as_raw_msb)));
   end

   always_comb begin
      result  = bit_y;
      fl_nxt  = '0;
      fl_mask = '0;
      case (op_sel)
         OP_ADD, OP_SUB: begin
            result         = as_sum;
            fl_nxt[FLG_N]  = n_arith;
            fl_nxt[FLG_Z]  = (as_sum == '0);
            fl_nxt[FLG_C]  = as_cout;
            fl_nxt[FLG_V]  = as_ovf;
            fl_mask        = '1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            fl_nxt[FLG_N]  = bit_y[MSB];
            fl_nxt[FLG_Z]  = (bit_y == '0);
            fl_mask[FLG_N] = 1'b1;
            fl_mask[FLG_Z] = 1'b1;
         end
         OP_CMP: begin
            result         = acc_in;
            fl_nxt[FLG_N]  = as_sum[MSB];
            fl_nxt[FLG_Z]  = (as_sum == '0);
            fl_nxt[FLG_C]  = as_cout;
            fl_mask        = 4'b1110;
         end
         OP_SHL: begin
            fl_nxt[FLG_N]  = acc_in[MSB-1];
            fl_nxt[FLG_Z]  = (bit_y == '0);
            fl_nxt[FLG_C]  = acc_in[MSB];
            fl_mask        = 4'b1110;
         end
         OP_SHR: begin
            fl_nxt[FLG_N]  = 1'b0;
            fl_nxt[FLG_Z]  = (bit_y == '0);
            fl_nxt[FLG_C]  = acc_in[0];
            fl_mask        = 4'b1110;
         end
         default: begin
            result  = opnd_in;
            fl_mask = '0;
         end
      endcase
   end

   alu8_flagreg #(.NF(NUM_FLAGS)) u_flags (
      .clk(clk), .rst(rst), .we(flag_we), .mask(fl_mask), .nxt(fl_nxt), .q(fl_q)
   );

   assign n_flag = fl_q[FLG_N];
   assign z_flag = fl_q[FLG_Z];
   assign c_flag = fl_q[FLG_C];
   assign v_flag = fl_q[FLG_V];

   assert_add_ovf_R1: assert property (@(posedge clk) disable iff (rst)
      (flag_we && op_sel == OP_ADD && !dec_mode) |=>
      (v_flag == (($past(acc_in[MSB]) == $past(opnd_in[MSB])) &&
                  ($past(result[MSB]) != $past(acc_in[MSB])))));
   assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (rst)
      is_cmp |-> (result == acc_in));
   assert_cmp_keeps_v_R4: assert property (@(posedge clk) disable iff (rst)
      (flag_we && is_cmp) |=> $stable(v_flag));
   assert_shr_clears_n_R6: assert property (@(posedge clk) disable iff (rst)
      (flag_we && op_sel == OP_SHR) |=> !n_flag);
   assert_zero_pos_R7: assert property (@(posedge clk) disable iff (rst)
      (flag_we && op_sel inside {OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR}) |=>
      !(z_flag && n_flag));
   assert_move_stable_R10: assert property (@(posedge clk) disable iff (rst)
      (op_sel >= OP_MOVE) |=> $stable({n_flag, z_flag, c_flag, v_flag}));
   assert_move_pass_R10: assert property (@(posedge clk) disable iff (rst)
      (op_sel >= OP_MOVE) |-> (result == opnd_in));

endmodule

// File: tb/tb_alu8_status.sv
`timescale 1ns/100ps
module tb_alu8_status;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] op_sel = 4'd8;
   logic [7:0] acc_in = '0, opnd_in = '0;
   logic       carry_in = 1'b0, dec_mode = 1'b0, flag_we = 1'b0;
   logic [7:0] result, result_l;
   logic       n_flag, z_flag, c_flag, v_flag;
   logic       nl_flag, zl_flag, cl_flag, vl_flag;

   int  n_checks = 0, n_fail = 0;
   bit  done = 1'b0;

   // bench model of flag state
   logic en, ez, ec, ev, enl;
   logic [7:0] exp_res;

   always #2.5 clk = ~clk;

   alu8_status #(.DATA_W(8), .LATE_DEC_N(1'b0)) dut (
      .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
      .carry_in(carry_in), .dec_mode(dec_mode), .flag_we(flag_we),
      .result(result), .n_flag(n_flag), .z_flag(z_flag), .c_flag(c_flag), .v_flag(v_flag)
   );

   alu8_status #(.DATA_W(8), .LATE_DEC_N(1'b1)) dut_late (
      .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
      .carry_in(carry_in), .dec_mode(dec_mode), .flag_we(flag_we),
      .result(result_l), .n_flag(nl_flag), .z_flag(zl_flag), .c_flag(cl_flag), .v_flag(vl_flag)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h (op %0d a %02h b %02h cin %0b dec %0b)",
                  req, act, expv, op_sel, acc_in, opnd_in, carry_in, dec_mode);
      end
   endtask

   function automatic int bcd2i(input logic [7:0] x);
      return int'(x[7:4]) * 10 + int'(x[3:0]);
   endfunction

   function automatic logic [7:0] i2bcd(input int v);
      logic [7:0] r;
      r[7:4] = 4'((v / 10) % 10);
      r[3:0] = 4'(v % 10);
      return r;
   endfunction

   task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic cin, input logic dec, input logic we);
      logic [8:0] t;
      logic [7:0] bb;
      logic n, z, c, v, nl, upd_c, upd_v;
      int s;
      n = en; z = ez; c = ec; v = ev; nl = enl;
      upd_c = 1'b0; upd_v = 1'b0;
      case (op)
         4'd0, 4'd1: begin // R1 R2 R8 R9
            bb = (op == 4'd1) ? ~b : b;
            t  = {1'b0, a} + {1'b0, bb} + {8'd0, cin};
            v  = (a[7] == bb[7]) && (t[7] != a[7]);
            if (dec) begin
               if (op == 4'd0) begin
                  s = bcd2i(a) + bcd2i(b) + int'(cin);
                  c = (s >= 100);
               end else begin
                  s = bcd2i(a) - bcd2i(b) - (1 - int'(cin));
                  c = (s >= 0);
                  if (s < 0) s = s + 100;
               end
               exp_res = i2bcd(s % 100);
            end else begin
               exp_res = t[7:0];
               c = t[8];
            end
            n = t[7]; nl = exp_res[7]; z = (exp_res == 8'h00);
            upd_c = 1'b1; upd_v = 1'b1;
         end
         4'd2, 4'd3, 4'd4: begin // R3
            exp_res = (op == 4'd2) ? (a & b) : (op == 4'd3) ? (a | b) : (a ^ b);
            n = exp_res[7]; nl = n; z = (exp_res == 8'h00);
         end
         4'd5: begin // R4
            t = {1'b0, a} + {1'b0, ~b} + 9'd1;
            exp_res = a;
            n = t[7]; nl = n; z = (t[7:0] == 8'h00); c = t[8]; upd_c = 1'b1;
         end
         4'd6: begin // R5
            exp_res = {a[6:0], 1'b0};
            n = a[6]; nl = n; c = a[7]; z = (exp_res == 8'h00); upd_c = 1'b1;
         end
         4'd7: begin // R6
            exp_res = {1'b0, a[7:1]};
            n = 1'b0; nl = 1'b0; c = a[0]; z = (exp_res == 8'h00); upd_c = 1'b1;
         end
         default: exp_res = b; // R10
      endcase
      if (we && op <= 4'd7) begin
         en = n; ez = z; enl = nl;
         if (upd_c) ec = c;
         if (upd_v) ev = v;
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic cin, input logic dec, input logic we, input string req);
      @(negedge clk);
      op_sel = op; acc_in = a; opnd_in = b; carry_in = cin; dec_mode = dec; flag_we = we;
      model(op, a, b, cin, dec, we);
      #1;
      chk({req, " result"}, result, exp_res);
      @(posedge clk);
      #1;
      chk({req, " N"}, {7'd0, n_flag}, {7'd0, en});
      chk({req, " Z"}, {7'd0, z_flag}, {7'd0, ez});
      chk({req, " C"}, {7'd0, c_flag}, {7'd0, ec});
      chk({req, " V"}, {7'd0, v_flag}, {7'd0, ev});
      chk({req, " late N R9"}, {7'd0, nl_flag}, {7'd0, enl});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; flag_we = 1'b0;
      @(posedge clk);
      #1;
      en = 0; ez = 0; ec = 0; ev = 0; enl = 0;
      chk("R12 reset flags", {4'd0, n_flag, z_flag, c_flag, v_flag}, 8'h00);
      chk("R12 reset late flags", {4'd0, nl_flag, zl_flag, cl_flag, vl_flag}, 8'h00);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      en = 0; ez = 0; ec = 0; ev = 0; enl = 0; exp_res = '0;
      repeat (2) @(posedge clk);
      do_reset();

      // directed corners
      run_op(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b1, "R1 signed overflow");
      run_op(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b1, "R1 R7 wrap to zero");
      run_op(4'd1, 8'h64, 8'h96, 1'b1, 1'b0, 1'b1, "R2 borrow");
      run_op(4'd1, 8'h80, 8'h01, 1'b1, 1'b0, 1'b1, "R2 overflow");
      run_op(4'd2, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b1, "R3 R7 and zero");
      run_op(4'd4, 8'h0F, 8'hF0, 1'b0, 1'b0, 1'b1, "R3 xor negative");
      run_op(4'd5, 8'h10, 8'h20, 1'b0, 1'b0, 1'b1, "R4 compare less");
      run_op(4'd5, 8'h33, 8'h33, 1'b0, 1'b0, 1'b1, "R4 R7 compare equal");
      run_op(4'd6, 8'h40, 8'h00, 1'b0, 1'b0, 1'b1, "R5 shift left bit6");
      run_op(4'd6, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1, "R5 R7 shift left to zero");
      run_op(4'd7, 8'h81, 8'h00, 1'b0, 1'b0, 1'b1, "R6 shift right");
      run_op(4'd0, 8'h79, 8'h01, 1'b0, 1'b1, 1'b1, "R8 R9 decimal 79+1");
      run_op(4'd0, 8'h99, 8'h01, 1'b0, 1'b1, 1'b1, "R8 R9 decimal 99+1");
      run_op(4'd1, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1, "R8 decimal 0-1");
      run_op(4'd1, 8'h50, 8'h25, 1'b1, 1'b1, 1'b1, "R8 decimal 50-25");
      run_op(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b1, "R1 setup flags");
      run_op(4'd8, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, "R10 move zero");
      run_op(4'd12, 8'h12, 8'h5A, 1'b0, 1'b0, 1'b1, "R10 unused code");
      run_op(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R11 update disabled");
      run_op(4'd7, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, "R11 shift disabled");
      do_reset();

      // random binary mode
      for (int i = 0; i < 3000; i++) begin
         run_op(4'($urandom_range(15)), 8'($urandom), 8'($urandom),
                1'($urandom_range(1)), 1'b0, ($urandom_range(7) != 0), "R1-7 random binary");
      end
      // random decimal mode with valid BCD
      for (int i = 0; i < 600; i++) begin
         run_op(4'($urandom_range(1)),
                {4'($urandom_range(9)), 4'($urandom_range(9))},
                {4'($urandom_range(9)), 4'($urandom_range(9))},
                1'($urandom_range(1)), 1'b1, 1'b1, "R8 random decimal");
      end
      do_reset();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule